// File: doc/BRIEF.md
# Prescaled Upcounting Timebase

This block is the timebase of a general-purpose timer. A free-running divider turns the timer clock into a count tick. A 16-bit counter climbs on each tick from zero to a programmed limit, then wraps to zero. At the wrap it raises a sticky overflow flag and a one-clock overflow pulse. The pulse is intended to feed the trigger inputs of a neighbouring timer, so several instances can be chained.

Software programs the block through a small synchronous write port. Four word addresses hold the control word, the divider value, the period limit, and the flag-clear strobe. The control word carries these fields:

- a run bit
- a bit that holds period writes back until the next wrap
- a bit that switches the count source from the divider to rising edges of an internal trigger
- a three-bit trigger selector

New divider values are never applied mid-period. They wait for a wrap.

Top module: `timebase_unit`

## Requirements
- R1: After reset the counter reads 0, the overflow flag is 0 and the overflow pulse is 0; the active divider and the period limit are both 0.
- R2: Writing 1 to bit 0 of address 0 (run bit) makes the counter advance from the second clock edge after the write edge; clearing it likewise takes one extra edge to act, after which the counter holds its value.
- R3: With divider value D active and the internal source selected, the counter advances once every D+1 clocks; the divider's internal count returns to zero while the timer is stopped, so a restart waits a full D+1 clocks.
- R4: The counter advances from 0 up to the active period limit P and, on the next advance, returns to 0 and signals an overflow; if the counter already exceeds P (limit lowered below it), the next advance is an overflow.
- R5: A value written to address 1 (divider) is used only after the next overflow; before any overflow the active divider is 0.
- R6: With bit 1 of address 0 clear (hold-back off), a value written to address 2 (period) is the active limit from the clock edge after the write.
- R7: With bit 1 of address 0 set, a value written to address 2 becomes the active limit only at the next overflow; the old limit governs until then.
- R8: With bit 2 of address 0 set, the counter advances once per rising edge of the trigger input chosen by bits 6:4 of address 0 (codes 0 to 3 select inputs 0 to 3). A trigger held high counts once. Unselected inputs are ignored. Codes 4 to 7 select nothing.
- R9: The overflow flag is set by each overflow and cleared by writing a value with bit 0 set to address 3; writing bit 0 clear has no effect, and an overflow in the same cycle as a clear leaves the flag set.
- R10: The overflow pulse is high for the one cycle following each overflow edge, in which the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word address |
| wrData | input | 16 | Register write data |
| trigIn | input | 4 | Internal trigger inputs |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfPulse | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the block with its default parameters: 16-bit counter and divider, four trigger inputs and a three-bit selector. The selector width lets the bench apply codes above the last trigger input and confirm that they count nothing. Small period limits, from 0 up to 9, and small dividers, from 0 up to 3, bring several wraps, divider hand-overs and period hand-overs into a few dozen cycles. A period limit of 0 makes every tick an overflow, which lets the bench force an overflow and a flag clear into the same cycle.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  // Strobes the control block hands to the counting datapath each cycle.
  typedef struct packed {
    logic run;      // synchronized run qualifier
    logic extMode;  // count on trigger edges instead of divider ticks
    logic extEdge;  // rising edge seen on the selected trigger
    logic bufOn;    // period writes wait for the next wrap
  } tbStrobe_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DIV  = 1;
  localparam int unsigned ADDR_PER  = 2;
  localparam int unsigned ADDR_FLAG = 3;

  localparam int unsigned BIT_RUN = 0;
  localparam int unsigned BIT_BUF = 1;
  localparam int unsigned BIT_EXT = 2;
  localparam int unsigned SEL_LSB = 4;

endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                ovfEvent,
  output tbStrobe_t           str,
  output logic [DIV_W-1:0]    divReg,
  output logic [CNT_W-1:0]    perReg,
  output logic                ovfFlag,
  output logic                ovfPulse
);

  logic              runReq;
  logic              runSync;
  logic              bufReg;
  logic              extReg;
  logic [SEL_W-1:0]  trigSel;
  logic [NUM_TRIG-1:0] trigPrev;
  logic [NUM_TRIG-1:0] trigRise;
  logic              selRise;

  logic wrCtrl, wrDiv, wrPer, wrFlag;

  assign wrCtrl = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign wrDiv  = wrEn && (wrAddr == ADDR_W'(ADDR_DIV));
  assign wrPer  = wrEn && (wrAddr == ADDR_W'(ADDR_PER));
  assign wrFlag = wrEn && (wrAddr == ADDR_W'(ADDR_FLAG));

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runReq  <= 1'b0;
      bufReg  <= 1'b0;
      extReg  <= 1'b0;
      trigSel <= '0;
      divReg  <= '0;
      perReg  <= '0;
    end else begin
      if (wrCtrl) begin
        runReq  <= wrData[BIT_RUN];
        bufReg  <= wrData[BIT_BUF];
        extReg  <= wrData[BIT_EXT];
        trigSel <= wrData[SEL_LSB +: SEL_W];
      end
      if (wrDiv) divReg <= wrData[DIV_W-1:0];
      if (wrPer) perReg <= wrData[CNT_W-1:0];
    end
  end

  // Run request passes through one synchronizing stage before it gates counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runSync <= 1'b0;
    else        runSync <= runReq;
  end

  // Per-input rising-edge detection; the selector then picks one or none.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trigPrev <= '0;
    else        trigPrev <= trigIn;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_rise
    assign trigRise[g] = trigIn[g] & ~trigPrev[g];
  end

  always_comb begin
    selRise = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (trigSel == SEL_W'(i)) selRise = trigRise[i];
    end
  end

  // Sticky flag: a simultaneous overflow beats the software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfFlag  <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= ovfEvent;
      if (ovfEvent)                  ovfFlag <= 1'b1;
      else if (wrFlag && wrData[0])  ovfFlag <= 1'b0;
    end
  end

  assign str.run     = runSync;
  assign str.extMode = extReg;
  assign str.extEdge = selRise;
  assign str.bufOn   = bufReg;

  // R9: every overflow leaves the flag set on the following cycle
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovfEvent) |-> ovfFlag);

  // R9: the flag falls only after a clear write with no overflow in that cycle
  a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovfFlag) |-> ($past(wrFlag) && $past(wrData[0]) && !$past(ovfEvent)));

  // R2: the synchronized run qualifier follows the request bit one edge late
  a_r2_run_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(str.run) |-> $past(runReq));

endmodule

// File: rtl/timebase_dp.sv
module timebase_dp
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tbStrobe_t        str,
  input  logic [DIV_W-1:0] divReg,
  input  logic [CNT_W-1:0] perReg,
  output logic [CNT_W-1:0] count,
  output logic             ovfEvent
);

  logic [DIV_W-1:0] psCnt;
  logic [DIV_W-1:0] divActive;
  logic [CNT_W-1:0] perShadow;
  logic [CNT_W-1:0] activePer;
  logic             psWrap;
  logic             advance;

  assign activePer = str.bufOn ? perShadow : perReg;
  assign psWrap    = (psCnt == divActive);
  assign advance   = str.run && (str.extMode ? str.extEdge : psWrap);
  // Magnitude test so a limit lowered beneath the count still wraps at once.
  assign ovfEvent  = advance && (count >= activePer);

  // Prescaler: idles at zero while stopped or while triggers drive the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        psCnt <= '0;
    else if (!str.run || str.extMode)  psCnt <= '0;
    else if (psWrap)                   psCnt <= '0;
    else                               psCnt <= psCnt + 1'b1;
  end

  // Counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (ovfEvent) count <= '0;
    else if (advance)  count <= count + 1'b1;
  end

  // Divider and period hand-over at the wrap; the period shadow tracks the
  // written value while hold-back is off so enabling it keeps the same limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divActive <= '0;
      perShadow <= '0;
    end else begin
      if (ovfEvent) divActive <= divReg;
      if (ovfEvent || !str.bufOn) perShadow <= perReg;
    end
  end

  // R2: the count moves only when the synchronized run qualifier was high
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> $past(str.run));

  // R4: each change is a single step up or a return to zero
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));

  // R3: the prescaler restarts from zero after every overflow
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovfEvent) |-> (psCnt == '0));

  // R5: the active divider moves only on an overflow
  a_r5_div_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (divActive != $past(divActive)) |-> $past(ovfEvent));

  // R8: in trigger mode a count change needs a selected rising edge
  a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != $past(count)) && $past(str.extMode)) |-> $past(str.extEdge));

  // R7: with hold-back on, the shadow limit is stable between wraps
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(str.bufOn) && !$past(ovfEvent)) |-> $stable(perShadow));

endmodule

// File: rtl/timebase_unit.sv
module timebase_unit
  import timebase_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned SEL_W    = 3,
  localparam int unsigned DATA_W  = (CNT_W > DIV_W) ? CNT_W : DIV_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic [CNT_W-1:0]    count,
  output logic                ovfFlag,
  output logic                ovfPulse
);

  tbStrobe_t        str;
  logic [DIV_W-1:0] divReg;
  logic [CNT_W-1:0] perReg;
  logic             ovfEvent;

  timebase_ctrl #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigIn(trigIn), .ovfEvent(ovfEvent),
    .str(str), .divReg(divReg), .perReg(perReg),
    .ovfFlag(ovfFlag), .ovfPulse(ovfPulse)
  );

  timebase_dp #(
    .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n),
    .str(str), .divReg(divReg), .perReg(perReg),
    .count(count), .ovfEvent(ovfEvent)
  );

  // R10: a pulse cycle always shows a zero count and a raised flag
  a_r10_pulse_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |-> ((count == '0) && ovfFlag));

endmodule

// File: tb/test_timebase_unit.sv
`timescale 1ns/1ps
module test_timebase_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  trigIn = '0;
  logic [15:0] count;
  logic        ovfFlag;
  logic        ovfPulse;

  int nChk = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  timebase_unit i_timebase_unit (
    .clk(clk), .rst_n(rst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigIn(trigIn),
    .count(count), .ovfFlag(ovfFlag), .ovfPulse(ovfPulse)
  );

  // Rows: divider, period, edges after the run write, expected count, expected flag
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{0, 5,  4, 3, 0},
    '{0, 5,  7, 0, 1},
    '{0, 5,  9, 2, 1},
    '{3, 4,  6, 0, 1},
    '{3, 4, 13, 1, 1},
    '{3, 4, 14, 2, 1},
    '{1, 2, 10, 0, 1},
    '{2, 0,  3, 0, 1}
  };

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  // Occupies exactly one rising edge; called and returning at a falling edge.
  task automatic wr(int addr, int data);
    wrEn = 1'b1;
    wrAddr = addr[1:0];
    wrData = data[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    trigIn = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic trigPulse(int idx, int len);
    trigIn[idx] = 1'b1;
    repeat (len) @(negedge clk);
    trigIn[idx] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 flag", ovfFlag, 0);
    chk("R1 pulse", ovfPulse, 0);

    // Vector walk: R3, R4, R5 (first period at divider 0, then D+1 per tick)
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      wr(1, VEC[v][0]);
      wr(2, VEC[v][1]);
      wr(0, 1);
      repeat (VEC[v][2]) @(negedge clk);
      chk("R3/R4/R5 vector count", count, VEC[v][3]);
      chk("R4 vector flag", ovfFlag, VEC[v][4]);
    end

    // R2: start lag, stop lag, hold while stopped
    doReset();
    wr(2, 50);
    wr(0, 1);
    @(negedge clk);
    chk("R2 no count one edge after run", count, 0);
    @(negedge clk);
    chk("R2 count on second edge", count, 1);
    wr(0, 0);
    repeat (5) @(negedge clk);
    chk("R2 hold after stop", count, 3);

    // R5: divider written mid-period is not used before a wrap
    doReset();
    wr(2, 9);
    wr(0, 1);
    wr(1, 3);
    repeat (3) @(negedge clk);
    chk("R5 old divider kept", count, 3);

    // R3: prescaler count cleared while stopped
    doReset();
    wr(1, 3);
    wr(0, 1);
    @(negedge clk);
    wr(2, 50);
    chk("R5 wrap with limit 0", ovfFlag, 1);
    wr(0, 0);
    repeat (3) @(negedge clk);
    wr(0, 1);
    repeat (4) @(negedge clk);
    chk("R3 restart waits full ratio", count, 0);
    @(negedge clk);
    chk("R3 tick after D+1", count, 1);

    // R6: unbuffered limit lowered below count wraps at next advance (R4)
    doReset();
    wr(2, 9);
    wr(0, 1);
    repeat (4) @(negedge clk);
    chk("R6 count before write", count, 3);
    wr(2, 2);
    @(negedge clk);
    chk("R6 immediate limit wrap", count, 0);
    chk("R4 flag on lowered limit", ovfFlag, 1);

    // R7: buffered limit applied only at wrap
    doReset();
    wr(2, 9);
    wr(0, 3);
    wr(2, 2);
    repeat (6) @(negedge clk);
    chk("R7 old limit governs", count, 6);
    repeat (4) @(negedge clk);
    chk("R7 wrap at old limit", count, 0);
    chk("R7 flag at wrap", ovfFlag, 1);
    repeat (2) @(negedge clk);
    chk("R7 new limit count", count, 2);
    @(negedge clk);
    chk("R7 wrap at new limit", count, 0);

    // R10 and R9: pulse timing, flag clearing
    doReset();
    wr(2, 3);
    wr(0, 1);
    repeat (4) @(negedge clk);
    chk("R10 no pulse before wrap", ovfPulse, 0);
    chk("R4 count at limit", count, 3);
    @(negedge clk);
    chk("R10 pulse at wrap", ovfPulse, 1);
    chk("R10 count zero with pulse", count, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", ovfPulse, 0);
    chk("R9 flag sticky", ovfFlag, 1);
    wr(0, 0);
    @(negedge clk);
    wr(3, 0);
    chk("R9 zero write ignored", ovfFlag, 1);
    wr(3, 1);
    chk("R9 clear", ovfFlag, 0);

    // R9: overflow in the clear cycle wins (limit 0, overflow every cycle)
    doReset();
    wr(0, 1);
    repeat (2) @(negedge clk);
    wr(3, 1);
    chk("R9 overflow beats clear", ovfFlag, 1);
    chk("R10 pulse on each overflow", ovfPulse, 1);

    // R8: trigger mode, selector 2
    doReset();
    wr(2, 50);
    wr(0, 32'h25);
    repeat (2) @(negedge clk);
    trigPulse(2, 1);
    trigPulse(2, 1);
    trigPulse(2, 1);
    chk("R8 three edges", count, 3);
    trigPulse(0, 1);
    trigPulse(3, 2);
    chk("R8 unselected ignored", count, 3);
    trigPulse(2, 4);
    chk("R8 held high counts once", count, 4);
    repeat (5) @(negedge clk);
    chk("R8 no divider ticks in trigger mode", count, 4);
    wr(0, 32'h55);
    @(negedge clk);
    trigPulse(2, 1);
    trigPulse(0, 1);
    chk("R8 code 5 selects nothing", count, 4);

    summary();
  end

endmodule